// File: doc/BRIEF.md
# Video test pattern frame sequencer

This block produces a continuous sequence of video frames on a streaming output that uses valid/ready flow control and marks each packet's first and last beats. A four-entry register bank sets it up. One register holds a run bit, one reports whether a frame is in progress, and two hold the requested frame width and height. When the run bit is set, the block takes a snapshot of the width and height at each frame boundary. It then emits a short control packet that describes the next image packet, followed by that image packet. The image is a set of vertical colour bars.

The output format is fixed at build time by a parameter: progressive or interlaced. In interlaced mode one snapshot serves two fields. The first field carries the even lines of the frame and the second carries the odd lines. Each field has its own control packet in front of it. Width and height values outside the legal range are pulled to the nearest limit when the snapshot is taken. Clearing the run bit stops the block only once the current frame, including both of its fields, has been sent.

Top module: `tpg_frame_seq`

## Requirements
- R1: The register bank decodes `reg_addr` as follows: 0 = run control (bit 0 = go), 1 = status (bit 0 = busy), 2 = width, 3 = height. Unused bits of entries 0 and 1 read 0, writes to entry 1 are ignored, and entries 2 and 3 read back the raw written value. Reads are combinational from `reg_addr`. After reset, go = 0, width = MAX_W and height = MAX_H.
- R2: While go is 0 and no frame is in progress, `st_valid` stays 0 and status reads 0.
- R3: Width and height are sampled once, in the idle cycle in which go is seen as 1. Writes to the registers after that cycle do not change any beat of the frame.
- R4: Clearing go while a frame is in progress does not cut that frame short: it completes (in interlaced mode, both fields) and no further frame starts.
- R5: Status reads 1 from the cycle after sampling until the last beat of the frame is accepted. Between two frames there is at least one cycle in which it reads 0.
- R6: A control packet is 10 beats long. Beat 0 is 0x000F. Beats 1..4 carry the sampled width, most significant nibble first. Beats 5..8 carry the field height the same way. Beat 9 carries the flag nibble: bit 3 = interlaced, bit 2 = second field. Only bits 3:0 are used, and the upper data bits are 0.
- R7: An image packet starts with a header beat 0x0000. It is followed by width × field-height pixel beats in row-major order. The pixel in column c has bar index b = floor(8·c/width) and data {5{b[2]}, 6{b[1]}, 5{b[0]}}.
- R8: `st_sop` is 1 exactly on the first beat of each packet and `st_eop` exactly on its last beat.
- R9: A beat is transferred only when `st_valid` and `st_ready` are both 1. While `st_valid` is 1 and `st_ready` is 0, valid, data and the markers hold their values.
- R10: With INTERLACED = 1, each frame sends control, image, control, image. The field height is floor(height/2). The flag nibble is 0x8 for the first field and 0xC for the second, and both fields use the single snapshot.
- R11: At sampling, a width below 32 becomes 32 and a width above MAX_W becomes MAX_W. The same rule applies to height, using 32 and MAX_H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| st_data | output | 16 | Stream beat data |
| st_valid | output | 1 | Beat present |
| st_ready | input | 1 | Sink accepts beat |
| st_sop | output | 1 | First beat of packet |
| st_eop | output | 1 | Last beat of packet |

## Verification
A progressive instance and an interlaced instance run side by side. Every accepted beat of every packet is compared against an arithmetic model of the control and bar layouts. The frames cover the minimum size, the maximum size, an odd size (which exposes floor rounding of both the bar index and the field height) and out-of-range writes (which separate clamping from wrap-around). The sink's ready signal is driven in three ways: always high, alternating, and pseudo-random. Comparing the runs shows whether the beat position advances only on accepted transfers and whether the outputs hold steady during stalls. Register writes made mid-frame, and go cleared mid-frame, test whether the snapshot and the stop point sit at the frame boundary rather than at a packet or field boundary.

// File: rtl/tpg_frame_seq.sv
module tpg_frame_seq #(
  parameter int MAX_W = 1920,
  parameter int MAX_H = 1080,
  parameter bit INTERLACED = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic [15:0] st_data,
  output logic        st_valid,
  input  logic        st_ready,
  output logic        st_sop,
  output logic        st_eop
);
  localparam logic [15:0] MINV  = 16'd32;
  localparam logic [15:0] MAXW  = 16'(MAX_W);
  localparam logic [15:0] MAXH  = 16'(MAX_H);
  localparam int          NBARS = 8;
  localparam logic [3:0]  CLAST = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_CTRL, S_IMG} st_t;

  st_t         state;
  logic        go_r, field, hdr;
  logic [15:0] w_r, h_r, sh_w, sh_fh, full_h;
  logic [15:0] col, row, acc;
  logic [16:0] nacc;
  logic [2:0]  bar;
  logic [3:0]  cbeat;
  logic        busy, fire, last_pix;

  function automatic logic [15:0] clampv(input logic [15:0] v, input logic [15:0] mx);
    return (v < MINV) ? MINV : (v > mx) ? mx : v;
  endfunction

  assign busy     = (state != S_IDLE);
  assign fire     = st_valid && st_ready;
  assign last_pix = (col == sh_w - 16'd1) && (row == sh_fh - 16'd1);
  assign nacc     = {1'b0, acc} + 17'(NBARS);
  assign full_h   = clampv(h_r, MAXH);

  always_comb begin
    unique case (reg_addr)
      2'd0: reg_rdata = {15'd0, go_r};
      2'd1: reg_rdata = {15'd0, busy};
      2'd2: reg_rdata = w_r;
      default: reg_rdata = h_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_r <= 1'b0;
      w_r  <= MAXW;
      h_r  <= MAXH;
    end else if (reg_wr) begin
      unique case (reg_addr)
        2'd0: go_r <= reg_wdata[0];
        2'd2: w_r  <= reg_wdata;
        2'd3: h_r  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sh_w  <= MINV;
      sh_fh <= MINV;
      field <= 1'b0;
      hdr   <= 1'b0;
      cbeat <= '0;
      col   <= '0;
      row   <= '0;
      acc   <= '0;
      bar   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (go_r) begin
          sh_w  <= clampv(w_r, MAXW);
          sh_fh <= INTERLACED ? {1'b0, full_h[15:1]} : full_h;
          field <= 1'b0;
          cbeat <= '0;
          state <= S_CTRL;
        end
        S_CTRL: if (fire) begin
          if (cbeat == CLAST) begin
            state <= S_IMG;
            hdr   <= 1'b1;
            col   <= '0;
            row   <= '0;
            acc   <= '0;
            bar   <= '0;
          end else begin
            cbeat <= cbeat + 4'd1;
          end
        end
        S_IMG: if (fire) begin
          if (hdr) begin
            hdr <= 1'b0;
          end else if (last_pix) begin
            if (INTERLACED && !field) begin
              field <= 1'b1;
              cbeat <= '0;
              state <= S_CTRL;
            end else begin
              state <= S_IDLE;
            end
          end else if (col == sh_w - 16'd1) begin
            col <= '0;
            row <= row + 16'd1;
            acc <= '0;
            bar <= '0;
          end else begin
            col <= col + 16'd1;
            if (nacc >= {1'b0, sh_w}) begin
              acc <= 16'(nacc - {1'b0, sh_w});
              bar <= bar + 3'd1;
            end else begin
              acc <= nacc[15:0];
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign st_valid = busy;
  assign st_sop   = (state == S_CTRL && cbeat == 4'd0) || (state == S_IMG && hdr);
  assign st_eop   = (state == S_CTRL && cbeat == CLAST) || (state == S_IMG && !hdr && last_pix);

  always_comb begin
    st_data = '0;
    if (state == S_CTRL) begin
      unique case (cbeat)
        4'd0: st_data = 16'h000F;
        4'd1: st_data = {12'd0, sh_w[15:12]};
        4'd2: st_data = {12'd0, sh_w[11:8]};
        4'd3: st_data = {12'd0, sh_w[7:4]};
        4'd4: st_data = {12'd0, sh_w[3:0]};
        4'd5: st_data = {12'd0, sh_fh[15:12]};
        4'd6: st_data = {12'd0, sh_fh[11:8]};
        4'd7: st_data = {12'd0, sh_fh[7:4]};
        4'd8: st_data = {12'd0, sh_fh[3:0]};
        default: st_data = {12'd0, INTERLACED, field, 2'b00};
      endcase
    end else if (state == S_IMG && !hdr) begin
      st_data = {{5{bar[2]}}, {6{bar[1]}}, {5{bar[0]}}};
    end
  end
endmodule

// File: rtl/tpg_frame_seq_chk.sv
module tpg_frame_seq_chk #(
  parameter int MAX_W = 1920
) (
  input logic        clk,
  input logic        rst_n,
  input logic        st_valid,
  input logic        st_ready,
  input logic        st_sop,
  input logic        st_eop,
  input logic [15:0] st_data,
  input logic        busy,
  input logic [15:0] sh_w,
  input logic [15:0] sh_fh
);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_sop) && $stable(st_eop));

  assert_snapshot_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(sh_w) && $stable(sh_fh));

  assert_width_clamped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sh_w >= 16'd32) && (sh_w <= 16'(MAX_W)));

  assert_busy_ends_on_eop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(st_valid && st_ready && st_eop));

  assert_sop_after_eop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_valid && st_ready && st_eop) && st_valid |-> st_sop);
endmodule

bind tpg_frame_seq tpg_frame_seq_chk #(.MAX_W(MAX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .st_sop(st_sop), .st_eop(st_eop), .st_data(st_data), .busy(busy),
  .sh_w(sh_w), .sh_fh(sh_fh)
);

// File: tb/sim_tpg_mon.sv
module sim_tpg_mon #(
  parameter int INTER = 0,
  parameter int MAXW  = 48,
  parameter int MAXH  = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  logic        ready,
  input  logic        sop,
  input  logic        eop,
  input  logic [15:0] data,
  input  int          exp_w,
  input  int          exp_h,
  output int          nchk,
  output int          nbad,
  output int          nframes
);
  int pkt = 0, idx = 0, fld = 0;
  int cw, ch, fh, n, c;
  logic [15:0] ed, pdata;
  logic psop, peop, stalled = 1'b0;
  logic [2:0] b;

  initial begin nchk = 0; nbad = 0; nframes = 0; end

  function automatic int clampi(input int v, input int mx);
    return (v < 32) ? 32 : (v > mx) ? mx : v;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) begin
        nchk++;
        if (!(valid && data == pdata && sop == psop && eop == peop)) begin
          nbad++;
          $display("FAIL R9 stall hold: data=%h sop=%b eop=%b valid=%b exp data=%h sop=%b eop=%b valid=1",
                   data, sop, eop, valid, pdata, psop, peop);
        end
      end
      stalled = valid && !ready;
      pdata = data; psop = sop; peop = eop;
      if (valid && ready) begin
        cw = clampi(exp_w, MAXW);
        ch = clampi(exp_h, MAXH);
        fh = INTER ? ch / 2 : ch;
        if (pkt == 0) begin
          n = 10;
          if (idx == 0) ed = 16'h000F;
          else if (idx <= 4) ed = 16'((cw >> (4 * (4 - idx))) & 15);
          else if (idx <= 8) ed = 16'((fh >> (4 * (8 - idx))) & 15);
          else ed = 16'((INTER << 3) | (fld << 2));
        end else begin
          n = 1 + cw * fh;
          if (idx == 0) ed = 16'h0000;
          else begin
            c = (idx - 1) % cw;
            b = 3'((c * 8) / cw);
            ed = {{5{b[2]}}, {6{b[1]}}, {5{b[0]}}};
          end
        end
        nchk++;
        if (data != ed) begin
          nbad++;
          $display("FAIL %s %s beat %0d field %0d: act=%h exp=%h",
                   INTER ? "R10" : (pkt == 0 ? "R6" : "R7"),
                   pkt == 0 ? "control" : "image", idx, fld, data, ed);
        end
        nchk++;
        if (sop != (idx == 0) || eop != (idx == n - 1)) begin
          nbad++;
          $display("FAIL R8 markers beat %0d of %0d: act sop=%b eop=%b exp sop=%b eop=%b",
                   idx, n, sop, eop, idx == 0, idx == n - 1);
        end
        if (idx == n - 1) begin
          idx = 0;
          if (pkt == 0) pkt = 1;
          else begin
            pkt = 0;
            if (INTER != 0 && fld == 0) fld = 1;
            else begin fld = 0; nframes++; end
          end
        end else idx++;
      end
    end
  end
endmodule

// File: tb/sim_tpg_frame_seq.sv
module sim_tpg_frame_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 48;
  localparam int MH = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rd0, rd1, d0, d1;
  logic v0, v1, s0, s1, e0, e1;
  logic ready = 1'b1;
  int rmode = 0;
  int exp_w = MW, exp_h = MH;
  int checks = 0, bad = 0, cycles = 0;
  int c0, b0, f0, c1, b1, f1;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tpg_frame_seq #(.MAX_W(MW), .MAX_H(MH), .INTERLACED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd0), .st_data(d0), .st_valid(v0), .st_ready(ready), .st_sop(s0), .st_eop(e0));
  tpg_frame_seq #(.MAX_W(MW), .MAX_H(MH), .INTERLACED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd1), .st_data(d1), .st_valid(v1), .st_ready(ready), .st_sop(s1), .st_eop(e1));

  sim_tpg_mon #(.INTER(0), .MAXW(MW), .MAXH(MH)) m0 (
    .clk(clk), .rst_n(rst_n), .valid(v0), .ready(ready), .sop(s0), .eop(e0), .data(d0),
    .exp_w(exp_w), .exp_h(exp_h), .nchk(c0), .nbad(b0), .nframes(f0));
  sim_tpg_mon #(.INTER(1), .MAXW(MW), .MAXH(MH)) m1 (
    .clk(clk), .rst_n(rst_n), .valid(v1), .ready(ready), .sop(s1), .eop(e1), .data(d1),
    .exp_w(exp_w), .exp_h(exp_h), .nchk(c1), .nbad(b1), .nframes(f1));

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks + c0 + c1, bad + b0 + b1);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] v);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output int r0, output int r1);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    r0 = int'(rd0); r1 = int'(rd1);
  endtask

  task automatic wait_idle();
    int x0, x1;
    forever begin
      rreg(2'd1, x0, x1);
      if (x0 == 0 && x1 == 0 && !v0 && !v1) break;
    end
  endtask

  task automatic one_frame(input string tag);
    int a0, a1, pf0, pf1, pb;
    pf0 = f0; pf1 = f1; pb = b0 + b1;
    wreg(2'd0, 16'h0001);
    rreg(2'd1, a0, a1);
    chk(a0 == 1 && a1 == 1, "R5 status busy during frame", a0 + a1, 2);
    wreg(2'd0, 16'h0000);
    wait_idle();
    chk(f0 == pf0 + 1, "R4 progressive single frame after go cleared", f0, pf0 + 1);
    chk(f1 == pf1 + 1, "R4 R10 interlaced single frame after go cleared", f1, pf1 + 1);
    chk(b0 + b1 == pb, tag, b0 + b1, pb);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? logic'(cycles[0]) : lfsr[0];
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++;
        $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
        summary();
        $finish;
      end
    end
  end

  initial begin
    int a0, a1, gaps, start;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rreg(2'd0, a0, a1); chk(a0 == 0 && a1 == 0, "R1 reset go", a0 + a1, 0);
    rreg(2'd1, a0, a1); chk(a0 == 0 && a1 == 0, "R1 reset status", a0 + a1, 0);
    rreg(2'd2, a0, a1); chk(a0 == MW && a1 == MW, "R1 reset width", a0, MW);
    rreg(2'd3, a0, a1); chk(a0 == MH && a1 == MH, "R1 reset height", a0, MH);

    wreg(2'd0, 16'hFFFE);
    rreg(2'd0, a0, a1); chk(a0 == 0, "R1 unused control bits read 0", a0, 0);
    wreg(2'd1, 16'hFFFF);
    rreg(2'd1, a0, a1); chk(a0 == 0, "R1 status write ignored", a0, 0);
    repeat (20) begin
      @(negedge clk);
      chk(!v0 && !v1, "R2 no output while go is 0", int'(v0) + int'(v1), 0);
    end

    wreg(2'd2, 16'd32); wreg(2'd3, 16'd32);
    exp_w = 32; exp_h = 32; rmode = 0;
    one_frame("R6 R7 minimum frame, ready held high");

    wreg(2'd2, 16'd48); wreg(2'd3, 16'd40);
    exp_w = 48; exp_h = 40; rmode = 2;
    begin
      int pf0, pb;
      pf0 = f0; pb = b0 + b1;
      wreg(2'd0, 16'hFFFF);
      rreg(2'd0, a0, a1); chk(a0 == 1, "R1 go reads 1 only in bit 0", a0, 1);
      rreg(2'd1, a0, a1); chk(a0 == 1 && a1 == 1, "R5 status busy", a0 + a1, 2);
      wreg(2'd0, 16'h0000);
      wreg(2'd2, 16'd33); wreg(2'd3, 16'd35);
      wait_idle();
      chk(f0 == pf0 + 1, "R4 frame completes after go cleared mid-frame", f0, pf0 + 1);
      chk(b0 + b1 == pb, "R3 mid-frame writes leave frame unchanged", b0 + b1, pb);
    end

    exp_w = 33; exp_h = 35; rmode = 1;
    one_frame("R7 R10 odd size, alternating ready");

    wreg(2'd2, 16'd5); wreg(2'd3, 16'd1000);
    rreg(2'd2, a0, a1); chk(a0 == 5, "R1 width reads raw value", a0, 5);
    exp_w = 5; exp_h = 1000; rmode = 2;
    one_frame("R11 clamp low width, high height");

    wreg(2'd2, 16'hFFFF); wreg(2'd3, 16'd3);
    exp_w = 65535; exp_h = 3; rmode = 0;
    one_frame("R11 clamp high width, low height");

    gaps = 0; start = f0;
    wreg(2'd0, 16'h0001);
    @(posedge clk); #1 reg_addr = 2'd1;
    while (f0 < start + 2) begin
      @(negedge clk);
      if (f0 > start && rd0 == 16'd0) gaps++;
    end
    wreg(2'd0, 16'h0000);
    wait_idle();
    chk(gaps >= 1, "R5 status drops between back-to-back frames", gaps, 1);
    chk(f0 >= start + 2, "R4 frames repeat while go held", f0, start + 2);
    repeat (10) begin
      @(negedge clk);
      chk(!v0 && !v1, "R2 halted after go cleared", int'(v0) + int'(v1), 0);
    end

    summary();
    $finish;
  end
endmodule